// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit produces the bit clocking for a CAN controller. A programmable prescaler turns the peripheral clock into time quanta. The unit then walks every nominal bit through three parts: a one-quantum sync segment, a first timing segment, and a second timing segment. At the boundary between the two timing segments it samples the received line and pulses a sample strobe. At the start of every sync segment it pulses a transmit-point strobe, where the protocol engine may change its output bit.

The receive line goes through a two-flop synchronizer. Only recessive-to-dominant transitions are treated as synchronizing edges. During bus idle or start of frame, the controller raises the hard-sync enable, and an edge then restarts the bit. Otherwise an edge resynchronizes the bit clock. A late edge lengthens the first timing segment. An early edge shortens the second one. In both cases the correction is limited by the programmed jump width.

The timing fields are checked continuously. While they break the allowed ranges, an error flag is raised and bit timing stops.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2*(brp+1) clock cycles. With no synchronizing edges, tx_stb pulses every 2*(brp+1)*(3+tseg1+tseg2) cycles.
- R2: The configuration is valid only when all of these hold:
  - tseg1 > tseg2 >= sjw
  - tseg2 >= 1
  - tseg1 >= 3
  - tseg1+tseg2 >= 5

  cfg_err is high one cycle after the fields become invalid, and low one cycle after they become valid. While cfg_err is held, neither strobe pulses. When the fields become valid again, bit timing restarts at a sync segment.
- R3: rx_in reaches the sampling logic through two flops. rx_bit changes only in the cycle in which sample_stb is high, and it then holds the synchronized line value, with 1 meaning recessive.
- R4: sample_stb is a one-cycle pulse at the end of time segment 1, which normally lasts tseg1+1 quanta. Time segment 2 then lasts tseg2+1 quanta, so the next tx_stb comes 2*(brp+1)*(tseg2+1) cycles after sample_stb when no edge intervenes.
- R5: tx_stb is a one-cycle pulse at the start of each sync segment. It never coincides with sample_stb.
- R6: Only a 1-to-0 transition of the synchronized line counts as an edge. An edge is acted on at the end of the quantum in which it is detected. Rising transitions have no effect on the strobes.
- R7: An edge in time segment 1 that ends at quantum index q (0-based) lengthens that segment by min(q+1, sjw+1) quanta.
- R8: An edge in time segment 2 at quantum index q has error e = tseg2+1-q. If e <= sjw+1, the next quantum is a sync segment. Otherwise time segment 2 is shortened by sjw+1 quanta.
- R9: At most one edge is used between two consecutive sample points, and later edges in that window are ignored. An edge in the sync segment uses up the window without changing timing.
- R10: When hsync_en is high, any edge makes the next quantum the first quantum of time segment 1. No tx_stb is produced for it, and resynchronization is blocked until the next sample point.
- R11: During reset, rx_bit is 1, sample_stb and tx_stb are 0, and cfg_err is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brp | input | 6 | Prescaler field; quantum = 2*(brp+1) clocks |
| tseg1 | input | 4 | Time segment 1 field; length tseg1+1 quanta |
| tseg2 | input | 3 | Time segment 2 field; length tseg2+1 quanta |
| sjw | input | 2 | Jump width field; maximum correction sjw+1 quanta |
| rx_in | input | 1 | Asynchronous receive line, 1 = recessive |
| hsync_en | input | 1 | Hard-sync enable (bus idle or start of frame) |
| cfg_err | output | 1 | High while the timing fields are invalid |
| rx_bit | output | 1 | Bit value taken at the last sample point |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| tx_stb | output | 1 | One-cycle pulse at the start of each sync segment |

## Verification
The bench places edges at the start of time segment 1, just after the sample point, and inside time segment 2 with hard sync on. If the sign of the phase error were wrong, the late-edge bit would shrink instead of grow. A missing jump-width clip would show up as an overshoot past nominal plus (sjw+1) quanta. A hard sync treated as a plain resync would produce a transmit strobe before the next sample strobe. The bench also changes the configuration to invalid sets, where a weak check would let strobes run, and back again. A second edge in the same window checks that a design cannot correct twice.

// File: rtl/cbt_pkg.sv
// Shared types for the CAN bit timing unit.
package cbt_pkg;
    // Part of the nominal bit currently being timed.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;
endpackage

// File: rtl/cbt_cfg_check.sv
// Validates the timing fields and registers the result.
// Assumes the fields are quasi-static; a one-cycle latency is acceptable.
module cbt_cfg_check #(
    parameter int TS1_W      = 4,
    parameter int TS2_W      = 3,
    parameter int SJW_W      = 2,
    parameter int MIN_TS1    = 3,
    parameter int MIN_TS2    = 1,
    parameter int MIN_BIT_TQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    output logic             cfg_ok
);
    localparam int A_W = (TS1_W > TS2_W) ? TS1_W : TS2_W;
    localparam int S_W = ((A_W > SJW_W) ? A_W : SJW_W) + 2;
    localparam logic [S_W-1:0] MIN1  = S_W'(MIN_TS1);
    localparam logic [S_W-1:0] MIN2  = S_W'(MIN_TS2);
    localparam logic [S_W-1:0] MINSM = S_W'(MIN_BIT_TQ - 3);

    logic [S_W-1:0] t1_x, t2_x, sj_x;
    logic           valid;

    // Widen the fields and evaluate every range rule.
    always_comb begin
        t1_x  = S_W'(tseg1);
        t2_x  = S_W'(tseg2);
        sj_x  = S_W'(sjw);
        valid = (t1_x > t2_x) && (t2_x >= sj_x) && (t2_x >= MIN2)
             && (t1_x >= MIN1) && ((t1_x + t2_x) >= MINSM);
    end

    // Register the verdict so downstream logic sees a clean level.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_ok <= 1'b0;
        else        cfg_ok <= valid;
    end
endmodule

// File: rtl/cbt_prescaler.sv
// Divides the clock into time quanta of 2*(brp+1) cycles.
// Emits tq_tick in the last cycle of each quantum; held in reset while the
// configuration is invalid.
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);
    localparam int C_W = BRP_W + 1;

    logic [C_W-1:0] cnt;

    // Last cycle of a quantum is count 2*brp+1.
    assign tq_tick = cfg_ok && (cnt == {brp, 1'b1});

    // Free-running quantum counter, cleared at wrap or when timing is off.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!cfg_ok || tq_tick) cnt <= '0;
        else                         cnt <= cnt + C_W'(1);
    end

    // R1: a quantum is at least two cycles, so ticks never repeat back to back
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> !tq_tick);
endmodule

// File: rtl/cbt_rx_sync.sv
// Two-flop synchronizer for the receive line plus a delay stage used to
// detect recessive-to-dominant transitions. Resets to recessive.
module cbt_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic meta, sync, prev;

    // Metastability chain and one-cycle history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b1;
            sync <= 1'b1;
            prev <= 1'b1;
        end else begin
            meta <= rx_in;
            sync <= meta;
            prev <= sync;
        end
    end

    assign rx_s = sync;
    assign fall = prev & ~sync;

    // R6: a detected edge is a single cycle (the line must rise again first)
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/cbt_bit_fsm.sv
// Walks each bit through sync, time segment 1 and time segment 2 on quantum
// ticks, applies hard sync and jump-width limited resynchronization, and
// produces registered sample and transmit-point strobes.
// Assumes edges are acted on at the end of the quantum that contains them
// and that one correction is allowed between consecutive sample points.
module cbt_bit_fsm
    import cbt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic             tq_tick,
    input  logic             fall,
    input  logic             rx_s,
    input  logic             hsync_en,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    output logic             sample_stb,
    output logic             tx_stb,
    output logic             rx_bit
);
    localparam int A_W = (TS1_W > TS2_W) ? TS1_W : TS2_W;
    localparam int L_W = ((A_W > SJW_W) ? A_W : SJW_W) + 1;
    localparam logic [L_W-1:0] ONE = L_W'(1);

    seg_e           seg;
    logic [L_W-1:0] q;
    logic [L_W-1:0] lim1, lim2;
    logic           done;
    logic           pend;

    logic           edge_any, use_rs, shrink_now;
    logic [L_W-1:0] jump, q_nx, ext, lim1_n, err2, lim2_n;

    // Correction arithmetic for the current quantum.
    always_comb begin
        edge_any   = fall | pend;
        use_rs     = edge_any & ~done & ~hsync_en;
        jump       = L_W'(sjw) + ONE;
        q_nx       = q + ONE;
        ext        = (q_nx > jump) ? jump : q_nx;
        lim1_n     = (use_rs && seg == SEG_TS1) ? lim1 + ext : lim1;
        err2       = lim2 - q + ONE;
        shrink_now = use_rs && (seg == SEG_TS2) && (err2 <= jump);
        lim2_n     = (use_rs && seg == SEG_TS2 && !shrink_now) ? lim2 - jump : lim2;
    end

    // Segment sequencing, synchronization and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg        <= SEG_SYNC;
            q          <= '0;
            lim1       <= '0;
            lim2       <= '0;
            done       <= 1'b0;
            pend       <= 1'b0;
            sample_stb <= 1'b0;
            tx_stb     <= 1'b0;
            rx_bit     <= 1'b1;
        end else begin
            sample_stb <= 1'b0;
            tx_stb     <= 1'b0;
            if (!cfg_ok) begin
                seg  <= SEG_SYNC;
                q    <= '0;
                done <= 1'b0;
                pend <= 1'b0;
            end else if (!tq_tick) begin
                if (fall) pend <= 1'b1;
            end else begin
                pend <= 1'b0;
                if (edge_any && hsync_en) begin
                    seg  <= SEG_TS1;
                    q    <= '0;
                    lim1 <= L_W'(tseg1);
                    done <= 1'b1;
                end else begin
                    case (seg)
                        SEG_SYNC: begin
                            seg  <= SEG_TS1;
                            q    <= '0;
                            lim1 <= L_W'(tseg1);
                            if (edge_any) done <= 1'b1;
                        end
                        SEG_TS1: begin
                            lim1 <= lim1_n;
                            if (edge_any) done <= 1'b1;
                            if (q == lim1_n) begin
                                seg        <= SEG_TS2;
                                q          <= '0;
                                lim2       <= L_W'(tseg2);
                                done       <= 1'b0;
                                sample_stb <= 1'b1;
                                rx_bit     <= rx_s;
                            end else begin
                                q <= q_nx;
                            end
                        end
                        default: begin
                            lim2 <= lim2_n;
                            if (edge_any) done <= 1'b1;
                            if (shrink_now || q == lim2_n) begin
                                seg    <= SEG_SYNC;
                                q      <= '0;
                                tx_stb <= 1'b1;
                            end else begin
                                q <= q_nx;
                            end
                        end
                    endcase
                end
            end
        end
    end

    // R5: the sync segment is a single quantum
    sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_SYNC) |-> (q == '0));

    // R7: time segment 1 never runs past its (possibly lengthened) end
    ts1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_TS1) |-> (q <= lim1));

    // R8: time segment 2 never runs past its (possibly shortened) end
    ts2_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_TS2) |-> (q <= lim2));

    // R10: a hard-sync edge lands on the first quantum of time segment 1
    hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && tq_tick && hsync_en && edge_any) |=>
            (seg == SEG_TS1 && q == '0 && !tx_stb));
endmodule

// File: rtl/can_bit_timing.sv
// Top of the CAN bit timing unit: configuration check, quantum prescaler,
// receive synchronizer and bit-segment sequencer.
// Assumes rx_in is asynchronous and the timing fields change only rarely.
module can_bit_timing #(
    parameter int BRP_W = 6,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    input  logic [SJW_W-1:0] sjw,
    input  logic             rx_in,
    input  logic             hsync_en,
    output logic             cfg_err,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             tx_stb
);
    logic cfg_ok, tq_tick, rx_s, fall;

    cbt_cfg_check #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .tseg1(tseg1), .tseg2(tseg2), .sjw(sjw),
        .cfg_ok(cfg_ok)
    );

    cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .brp(brp), .tq_tick(tq_tick)
    );

    cbt_rx_sync u_rx (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_s(rx_s), .fall(fall)
    );

    cbt_bit_fsm #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .tq_tick(tq_tick),
        .fall(fall), .rx_s(rx_s), .hsync_en(hsync_en), .tseg1(tseg1),
        .tseg2(tseg2), .sjw(sjw), .sample_stb(sample_stb), .tx_stb(tx_stb),
        .rx_bit(rx_bit)
    );

    assign cfg_err = ~cfg_ok;

    // R2: a settled error keeps both strobes quiet
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> (!sample_stb && !tx_stb));

    // R3: the sampled bit only moves at a sample point
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(rx_bit));

    // R4: the sample strobe lasts one cycle
    smp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R5: transmit point and sample point never coincide
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));
endmodule

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] brp = 6'd0;
    logic [3:0] tseg1 = 4'd4;
    logic [2:0] tseg2 = 3'd3;
    logic [1:0] sjw = 2'd1;
    logic       rx_in = 1'b1;
    logic       hsync_en = 1'b0;
    logic       cfg_err, rx_bit, sample_stb, tx_stb;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit ended = 1'b0;

    can_bit_timing u_dut (
        .clk(clk), .rst_n(rst_n), .brp(brp), .tseg1(tseg1), .tseg2(tseg2),
        .sjw(sjw), .rx_in(rx_in), .hsync_en(hsync_en), .cfg_err(cfg_err),
        .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_ok, m_pc, m_r1, m_r2, m_r3, m_pend;
    int m_pos, m_sp, m_end, m_done;
    int m_rx, m_smp, m_tx;

    function automatic int cfg_valid(int b1, int b2, int j);
        return (b1 > b2 && b2 >= j && b2 >= 1 && b1 >= 3 && b1 + b2 >= 5) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int tick, fedge, ev, usable, jw, ext, err;
        started <= 1'b1;
        if (!rst_n) begin
            m_ok = 0; m_pc = 0; m_r1 = 1; m_r2 = 1; m_r3 = 1; m_pend = 0;
            m_pos = 0; m_sp = 0; m_end = 0; m_done = 0;
            m_rx = 1; m_smp = 0; m_tx = 0;
        end else begin
            tick  = (m_ok != 0 && m_pc == 2 * int'(brp) + 1) ? 1 : 0;
            fedge = (m_r3 == 1 && m_r2 == 0) ? 1 : 0;
            jw    = int'(sjw) + 1;
            m_smp = 0;
            m_tx  = 0;
            if (m_ok == 0) begin
                m_pos = 0; m_done = 0; m_pend = 0;
            end else if (tick == 0) begin
                if (fedge != 0) m_pend = 1;
            end else begin
                ev = (fedge != 0 || m_pend != 0) ? 1 : 0;
                m_pend = 0;
                if (ev != 0 && hsync_en) begin
                    m_pos = 1; m_sp = 1 + int'(tseg1); m_end = m_sp + int'(tseg2) + 1;
                    m_done = 1;
                end else begin
                    usable = (ev != 0 && m_done == 0) ? 1 : 0;
                    if (ev != 0) m_done = 1;
                    if (m_pos == 0) begin
                        m_pos = 1; m_sp = 1 + int'(tseg1); m_end = m_sp + int'(tseg2) + 1;
                    end else if (m_pos <= m_sp) begin
                        if (usable != 0) begin
                            ext = (m_pos < jw) ? m_pos : jw;
                            m_sp += ext; m_end += ext;
                        end
                        if (m_pos == m_sp) begin
                            m_smp = 1; m_rx = m_r2; m_done = 0;
                            m_end = m_sp + int'(tseg2) + 1;
                        end
                        m_pos++;
                    end else begin
                        if (usable != 0) begin
                            err = m_end - m_pos + 1;
                            if (err <= jw) m_end = m_pos;
                            else m_end -= jw;
                        end
                        if (m_pos == m_end) begin
                            m_pos = 0; m_tx = 1;
                        end else begin
                            m_pos++;
                        end
                    end
                end
            end
            m_pc = (m_ok == 0 || tick != 0) ? 0 : m_pc + 1;
            m_ok = cfg_valid(int'(tseg1), int'(tseg2), int'(sjw));
            m_r3 = m_r2; m_r2 = m_r1; m_r1 = int'(rx_in);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !ended) begin
            check("R2 cfg_err model", int'(cfg_err), (m_ok != 0) ? 0 : 1);
            check("R3 rx_bit model", int'(rx_bit), m_rx);
            check("R4 sample_stb model", int'(sample_stb), m_smp);
            check("R5 tx_stb model", int'(tx_stb), m_tx);
        end
    end

    task automatic summary();
        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            summary();
        end
    end

    task automatic wait_tx();
        do @(negedge clk); while (!tx_stb);
    endtask

    task automatic wait_smp();
        do @(negedge clk); while (!sample_stb);
    endtask

    // Cycles from a tx strobe to the next; drop rx at offset drop_at (0 = none).
    task automatic tx_period(input int drop_at, output int n);
        wait_tx();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == drop_at) rx_in = 1'b0;
        end while (!tx_stb);
    endtask

    // From a sample strobe to the next strobe of either kind.
    task automatic after_sample(input int drop_at, output int n, output int first_tx);
        wait_smp();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == drop_at) rx_in = 1'b0;
        end while (!tx_stb && !sample_stb);
        first_tx = tx_stb ? 1 : 0;
    endtask

    task automatic set_cfg(input int b, input int t1, input int t2, input int j);
        @(negedge clk);
        brp = 6'(b); tseg1 = 4'(t1); tseg2 = 3'(t2); sjw = 2'(j);
    endtask

    initial begin
        int n, ftx, quiet;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rx_bit in reset", int'(rx_bit), 1);
        check("R11 sample_stb in reset", int'(sample_stb), 0);
        check("R11 tx_stb in reset", int'(tx_stb), 0);
        check("R11 cfg_err in reset", int'(cfg_err), 1);
        rst_n = 1'b1;

        // R1 nominal 1-quantum=2 clocks, 10 quanta per bit
        wait_tx();
        tx_period(0, n);
        check("R1 period brp0 t1=4 t2=3", n, 20);

        // R1 / R4 with a slower prescaler
        set_cfg(2, 7, 4, 2);
        wait_tx(); wait_tx();
        tx_period(0, n);
        check("R1 period brp2 t1=7 t2=4", n, 2 * 3 * (3 + 7 + 4));
        after_sample(0, n, ftx);
        check("R4 sample to tx spacing", n, 2 * 3 * 5);
        check("R4 tx follows sample", ftx, 1);

        // R2 invalid settings hold timing off
        set_cfg(0, 3, 3, 0);
        repeat (3) @(negedge clk);
        check("R2 cfg_err tseg1<=tseg2", int'(cfg_err), 1);
        quiet = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_stb || tx_stb) quiet++;
        end
        check("R2 no strobes while invalid", quiet, 0);
        set_cfg(0, 5, 2, 3);
        repeat (3) @(negedge clk);
        check("R2 cfg_err tseg2<sjw", int'(cfg_err), 1);
        set_cfg(0, 7, 4, 2);
        repeat (3) @(negedge clk);
        check("R2 cfg_err cleared", int'(cfg_err), 0);

        // R3 dominant line reaches rx_bit at the next sample point
        wait_tx();
        @(negedge clk) rx_in = 1'b0;
        wait_smp();
        check("R3 rx_bit dominant", int'(rx_bit), 0);
        // R6 rising transition changes no timing
        @(negedge clk) rx_in = 1'b1;
        wait_tx();
        tx_period(0, n);
        check("R6 period after rising edge", n, 28);
        wait_smp();
        check("R3 rx_bit recessive", int'(rx_bit), 1);

        // R7 late edge lengthens the bit, clipped by the jump width
        tx_period(1, n);
        check_range("R7 late edge period", n, 29, 28 + 3 * 2);
        @(negedge clk) rx_in = 1'b1;
        wait_tx();

        // R8 early edge shortens time segment 2
        after_sample(1, n, ftx);
        check("R8 early edge tx comes first", ftx, 1);
        check_range("R8 early edge spacing", n, 2, 9);
        @(negedge clk) rx_in = 1'b1;
        wait_tx();

        // R9 second edge in one window is ignored
        wait_tx();
        @(negedge clk) rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
        rx_in = 1'b0;
        wait_tx();
        @(negedge clk) rx_in = 1'b1;
        tx_period(0, n);
        check("R9 period settles after double edge", n, 28);

        // R10 hard sync restarts the bit: sample comes before tx
        hsync_en = 1'b1;
        after_sample(2, n, ftx);
        check("R10 hard sync skips transmit point", ftx, 0);
        check_range("R10 hard sync to sample", n, 8 * 2, 8 * 2 + 2 + 6);
        @(negedge clk) rx_in = 1'b1;
        hsync_en = 1'b0;
        wait_tx();
        tx_period(0, n);
        check("R10 nominal after hard sync", n, 28);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule